// File: doc/BRIEF.md
# Serial Byte Transmitter with DMA Request Handshake

This block sends bytes on a single asynchronous serial line using a fixed frame of one start bit, eight data bits and one stop bit. A one-byte holding register sits in front of a shift register, so the next byte can be written while the current frame is still on the line. A small register bus sets the bit period, switches DMA mode on or off, writes data and reads status.

With DMA mode on, the block raises a request to an external DMA engine whenever the holding register becomes empty. The engine answers with an acknowledge strobe that carries one byte. Transmit requests come only from the holding-register state, with no link to any receive path. A transmit-done flag stays low while bytes keep arriving. It rises only when the last frame has fully left the shift register and no byte is waiting, so software can poll it before shutting the line down. Software clears the flag by writing 0 to its bit.

Register map (bus_addr): 0 = data (a write loads the holding register, a read returns it), 1 = control (bit 0 = DMA mode), 2 = bit-period divisor, 3 = status (bit 0 = holding empty, bit 1 = transmit done, bit 2 = overrun).

Top module: `serial_dma_tx`

## Requirements
- R1: After reset, tx is high, dma_req is low, status reads empty=1, done=1, overrun=0, control reads 0 and the divisor reads DIV_RST.
- R2: A frame is a low start bit, 8 data bits LSB first, then a high stop bit. Each bit lasts divisor clocks, and a divisor of 0 behaves as 1.
- R3: A data write clears status bit 0 from its write edge. On the first edge at which the shifter is idle and the holding register is full, the byte moves into the shifter and status bit 0 reads 1 from that edge.
- R4: Bytes written while a frame is in progress go out in write order, and none is lost or repeated.
- R5: While control bit 0 is 0, dma_req stays low. Clearing the bit drops a pending request.
- R6: While control bit 0 is 1, dma_req is high from the edge at which the holding register is empty, including the edge that sets the mode bit. It stays high until an acknowledge or a data write.
- R7: dma_ack with dma_data writes the byte into the holding register on that edge, and dma_req is low from that same edge.
- R8: Status bit 1 is set on the edge that ends a stop bit when no byte is waiting. It is cleared when a new frame is loaded, and it stays 0 across the end of a frame that has a byte waiting behind it.
- R9: A status write with bit 1 = 0 clears the transmit-done flag. Writing 1 to that bit has no effect.
- R10: A data write (bus or DMA) while the holding register is full is dropped and sets status bit 2. The bit stays set until a status write with bit 2 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data for bus_addr (combinational) |
| dma_req | output | 1 | Transmit request to DMA engine |
| dma_ack | input | 1 | DMA acknowledge, one byte per pulse |
| dma_data | input | DATA_W | Byte delivered with dma_ack |
| tx | output | 1 | Serial output, idles high |

## Verification
The bench builds the block with DIV_W=4 and DIV_RST=5. Every divisor from 0 to 15 is then legal, and a frame takes only 10 to 150 clocks. This makes the divisor-0 clamp, one-clock bits and many back-to-back frames cheap to run. DMA traffic uses a divisor of 3 with acknowledge delays of 0 to 3 clocks, so a request sometimes meets an idle shifter and sometimes a busy one.

// File: rtl/sdt_pkg.sv
package sdt_pkg;
  typedef enum logic [1:0] {SH_IDLE, SH_START, SH_DATA, SH_STOP} sh_state_t;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_DIV  = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  localparam int ST_EMPTY = 0;
  localparam int ST_DONE  = 1;
  localparam int ST_OVR   = 2;
endpackage

// File: rtl/sdt_baud.sv
module sdt_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_ns,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] last;

  always_comb begin
    last  = (div == '0) ? '0 : div - 1'b1;
    tick  = run && (cnt_q == last);
    cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sdt_shift.sv
module sdt_shift
  import sdt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_ns,
  input  logic              tick,
  input  logic              load_valid,
  input  logic [DATA_W-1:0] load_data,
  output logic              load_take,
  output logic              frame_end,
  output logic              busy,
  output logic              tx
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  sh_state_t         st_q, st_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              tx_q, tx_d;

  always_comb begin
    st_d      = st_q;
    sh_d      = sh_q;
    idx_d     = idx_q;
    load_take = 1'b0;
    frame_end = 1'b0;
    case (st_q)
      SH_IDLE: begin
        if (load_valid) begin
          load_take = 1'b1;
          sh_d      = load_data;
          idx_d     = '0;
          st_d      = SH_START;
        end
      end
      SH_START: begin
        if (tick) st_d = SH_DATA;
      end
      SH_DATA: begin
        if (tick) begin
          if (idx_q == LAST_IDX) begin
            st_d = SH_STOP;
          end else begin
            sh_d  = sh_q >> 1;
            idx_d = idx_q + 1'b1;
          end
        end
      end
      SH_STOP: begin
        if (tick) begin
          st_d      = SH_IDLE;
          frame_end = 1'b1;
        end
      end
      default: st_d = SH_IDLE;
    endcase

    case (st_d)
      SH_START: tx_d = 1'b0;
      SH_DATA:  tx_d = sh_d[0];
      default:  tx_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q  <= SH_IDLE;
      sh_q  <= '0;
      idx_q <= '0;
      tx_q  <= 1'b1;
    end else begin
      st_q  <= st_d;
      sh_q  <= sh_d;
      idx_q <= idx_d;
      tx_q  <= tx_d;
    end
  end

  assign busy = (st_q != SH_IDLE);
  assign tx   = tx_q;
endmodule

// File: rtl/sdt_regs.sv
module sdt_regs
  import sdt_pkg::*;
#(
  parameter int          DATA_W  = 8,
  parameter int          DIV_W   = 8,
  parameter int unsigned DIV_RST = 16
) (
  input  logic              clk,
  input  logic              rst_ns,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dma_ack,
  input  logic [DATA_W-1:0] dma_data,
  output logic              dma_req,
  input  logic              load_take,
  input  logic              frame_end,
  output logic              hold_full,
  output logic [DATA_W-1:0] hold_data,
  output logic [DIV_W-1:0]  div,
  output logic              dma_on,
  output logic              done_flag,
  output logic              ovr_flag
);
  logic              full_q, full_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              dma_q, dma_d;
  logic              done_q, done_d;
  logic              ovr_q, ovr_d;
  logic              req_q, req_d;
  logic              wr_data, wr_ctrl, wr_div, wr_stat;
  logic              take_cpu, take_dma, drop;

  always_comb begin
    wr_data  = bus_we && (bus_addr == A_DATA);
    wr_ctrl  = bus_we && (bus_addr == A_CTRL);
    wr_div   = bus_we && (bus_addr == A_DIV);
    wr_stat  = bus_we && (bus_addr == A_STAT);
    take_cpu = wr_data && !full_q;
    take_dma = dma_ack && !full_q && !wr_data;
    drop     = (wr_data && full_q) || (dma_ack && (full_q || wr_data));

    hold_d = hold_q;
    full_d = full_q;
    if (load_take) begin
      full_d = 1'b0;
    end else if (take_cpu) begin
      full_d = 1'b1;
      hold_d = bus_wdata;
    end else if (take_dma) begin
      full_d = 1'b1;
      hold_d = dma_data;
    end

    dma_d = wr_ctrl ? bus_wdata[0] : dma_q;
    div_d = wr_div  ? bus_wdata[DIV_W-1:0] : div_q;

    done_d = done_q;
    if (frame_end && !full_q)             done_d = 1'b1;
    else if (load_take)                   done_d = 1'b0;
    else if (wr_stat && !bus_wdata[ST_DONE]) done_d = 1'b0;

    ovr_d = ovr_q;
    if (drop)                                ovr_d = 1'b1;
    else if (wr_stat && !bus_wdata[ST_OVR])  ovr_d = 1'b0;

    req_d = dma_d && !full_d;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      full_q <= 1'b0;
      hold_q <= '0;
      div_q  <= DIV_W'(DIV_RST);
      dma_q  <= 1'b0;
      done_q <= 1'b1;
      ovr_q  <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      full_q <= full_d;
      hold_q <= hold_d;
      div_q  <= div_d;
      dma_q  <= dma_d;
      done_q <= done_d;
      ovr_q  <= ovr_d;
      req_q  <= req_d;
    end
  end

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = hold_q;
      A_CTRL:  bus_rdata = DATA_W'(dma_q);
      A_DIV:   bus_rdata = DATA_W'(div_q);
      default: bus_rdata = DATA_W'({ovr_q, done_q, ~full_q});
    endcase
  end

  assign dma_req   = req_q;
  assign hold_full = full_q;
  assign hold_data = hold_q;
  assign div       = div_q;
  assign dma_on    = dma_q;
  assign done_flag = done_q;
  assign ovr_flag  = ovr_q;
endmodule

// File: rtl/serial_dma_tx.sv
module serial_dma_tx #(
  parameter int          DATA_W  = 8,
  parameter int          DIV_W   = 8,
  parameter int unsigned DIV_RST = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              dma_req,
  input  logic              dma_ack,
  input  logic [DATA_W-1:0] dma_data,
  output logic              tx
);
  logic [1:0]        rst_pipe;
  logic              rst_ns;
  logic              load_take, frame_end, busy, tick;
  logic              hold_full, dma_on, done_flag, ovr_flag;
  logic [DATA_W-1:0] hold_data;
  logic [DIV_W-1:0]  div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  sdt_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_regs (
    .clk       (clk),
    .rst_ns    (rst_ns),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .dma_ack   (dma_ack),
    .dma_data  (dma_data),
    .dma_req   (dma_req),
    .load_take (load_take),
    .frame_end (frame_end),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .div       (div),
    .dma_on    (dma_on),
    .done_flag (done_flag),
    .ovr_flag  (ovr_flag)
  );

  sdt_baud #(.DIV_W(DIV_W)) u_baud (
    .clk    (clk),
    .rst_ns (rst_ns),
    .run    (busy),
    .div    (div),
    .tick   (tick)
  );

  sdt_shift #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_ns     (rst_ns),
    .tick       (tick),
    .load_valid (hold_full),
    .load_data  (hold_data),
    .load_take  (load_take),
    .frame_end  (frame_end),
    .busy       (busy),
    .tx         (tx)
  );
endmodule

// File: rtl/sdt_chk.sv
module sdt_chk
  import sdt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_ns,
  input logic              bus_we,
  input logic [1:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              dma_req,
  input logic              dma_ack,
  input logic              dma_on,
  input logic              hold_full,
  input logic              load_take,
  input logic              done_flag,
  input logic              ovr_flag,
  input logic              tx
);
  // R7
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    dma_req && dma_ack |=> !dma_req);

  // R5
  req_gate_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !dma_on |-> !dma_req);

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    dma_req && !dma_ack && !bus_we |=> dma_req);

  // R3
  empty_after_load_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    load_take |=> !hold_full);

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    load_take |=> !tx);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    done_flag |-> tx);

  // R10
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    ovr_flag && !(bus_we && bus_addr == A_STAT && !bus_wdata[ST_OVR]) |=> ovr_flag);
endmodule

bind serial_dma_tx sdt_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_ns    (rst_ns),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .dma_req   (dma_req),
  .dma_ack   (dma_ack),
  .dma_on    (dma_on),
  .hold_full (hold_full),
  .load_take (load_take),
  .done_flag (done_flag),
  .ovr_flag  (ovr_flag),
  .tx        (tx)
);

// File: tb/sim_serial_dma_tx.sv
module sim_serial_dma_tx;
  localparam int DW = 8;
  localparam int VW = 4;
  localparam int VR = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0;
  logic [1:0]    bus_addr = 2'd0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          dma_req;
  logic          dma_ack = 1'b0;
  logic [DW-1:0] dma_data = '0;
  logic          tx;

  int         n_chk = 0;
  int         n_bad = 0;
  int         cur_div = VR;
  bit         mon_en = 1'b0;
  bit         finished = 1'b0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  serial_dma_tx #(.DATA_W(DW), .DIV_W(VW), .DIV_RST(VR)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dma_req(dma_req),
    .dma_ack(dma_ack), .dma_data(dma_data), .tx(tx)
  );

  function automatic logic [7:0] stat_exp(bit empty, bit done, bit ovr);
    return {5'b0, ovr, done, empty};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bw(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic br(logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_done();
    logic [7:0] s;
    int t = 0;
    s = '0;
    while (!s[1] && t < 5000) begin
      @(negedge clk);
      br(2'd3, s);
      t++;
    end
    chk(s[1], "R8 done reached", s[1], 1);
  endtask

  task automatic send_cpu(logic [7:0] b);
    logic [7:0] s;
    int t = 0;
    s = '0;
    while (!s[0] && t < 5000) begin
      @(negedge clk);
      br(2'd3, s);
      t++;
    end
    bw(2'd0, b);
    exp_q.push_back(b);
  endtask

  // serial line monitor: checks R2 frame shape and R4 ordering
  always begin
    @(negedge clk);
    if (mon_en && tx === 1'b0) begin
      int d;
      bit ok;
      logic [7:0] got;
      d = cur_div;
      ok = 1'b1;
      got = '0;
      repeat (d - 1) @(negedge clk);
      if (tx !== 1'b0) ok = 1'b0;
      @(negedge clk);
      got[0] = tx;
      for (int k = 1; k < 8; k++) begin
        repeat (d) @(negedge clk);
        got[k] = tx;
      end
      repeat (d) @(negedge clk);
      if (tx !== 1'b1) ok = 1'b0;
      chk(ok, "R2 start/stop bit shape", ok, 1);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected frame", got, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(got == e, "R2 R4 frame data", got, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R4: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    void'($urandom(32'h1F2E3D4C));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_en = 1'b1;

    // R1 reset state
    chk(tx == 1'b1, "R1 tx idle", tx, 1);
    chk(dma_req == 1'b0, "R1 dma_req low", dma_req, 0);
    br(2'd3, s); chk(s == stat_exp(1, 1, 0), "R1 status", s, stat_exp(1, 1, 0));
    br(2'd1, s); chk(s == 8'd0, "R1 control", s, 0);
    br(2'd2, s); chk(s == 8'(VR), "R1 divisor", s, VR);

    // R5 no request while DMA mode off, holding empty
    repeat (8) @(negedge clk);
    chk(dma_req == 1'b0, "R5 no request when off", dma_req, 0);

    // R3 / R8 single byte by bus, divisor 4
    bw(2'd2, 8'd4); cur_div = 4;
    bw(2'd0, 8'hA5); exp_q.push_back(8'hA5);
    br(2'd3, s); chk(s[0] == 1'b0, "R3 empty clears on write", s[0], 0);
    @(negedge clk);
    br(2'd3, s); chk(s[0] == 1'b1, "R3 empty after load", s[0], 1);
    chk(s[1] == 1'b0, "R8 done cleared on load", s[1], 0);
    wait_done();
    chk(exp_q.size() == 0, "R8 done only after frame", exp_q.size(), 0);

    // R9 writing 1 leaves done, writing 0 clears it
    bw(2'd3, 8'hFF);
    br(2'd3, s); chk(s == stat_exp(1, 1, 0), "R9 write 1 no effect", s, stat_exp(1, 1, 0));
    bw(2'd3, 8'hFD);
    br(2'd3, s); chk(s == stat_exp(1, 0, 0), "R9 write 0 clears", s, stat_exp(1, 0, 0));

    // R10 overrun, R4 back-to-back, R8 done held low with byte waiting
    bw(2'd0, 8'h3C); exp_q.push_back(8'h3C);
    repeat (2) @(negedge clk);
    bw(2'd0, 8'hC3); exp_q.push_back(8'hC3);
    bw(2'd0, 8'h99);
    br(2'd3, s); chk(s == stat_exp(0, 0, 1), "R10 overrun on full write", s, stat_exp(0, 0, 1));
    br(2'd0, s); chk(s == 8'hC3, "R10 held byte kept", s, 8'hC3);
    wait_done();
    chk(exp_q.size() == 0, "R8 done not raised early", exp_q.size(), 0);
    br(2'd3, s); chk(s[2] == 1'b1, "R10 overrun sticky", s[2], 1);
    bw(2'd3, 8'hFB);
    br(2'd3, s); chk(s == stat_exp(1, 1, 0), "R10 overrun cleared", s, stat_exp(1, 1, 0));

    // R2 divisor 0 acts as 1
    bw(2'd2, 8'd0); cur_div = 1;
    send_cpu(8'h5A);
    wait_done();
    chk(exp_q.size() == 0, "R2 divisor zero frame", exp_q.size(), 0);

    // random bus traffic with random divisors (R2, R4)
    for (int c = 0; c < 4; c++) begin
      int dv;
      dv = 1 + int'($urandom % 6);
      bw(2'd2, 8'(dv)); cur_div = dv;
      for (int i = 0; i < 5; i++) send_cpu(8'($urandom));
      wait_done();
      chk(exp_q.size() == 0, "R4 random bus bytes sent", exp_q.size(), 0);
    end

    // DMA traffic (R6, R7)
    bw(2'd2, 8'd3); cur_div = 3;
    bw(2'd1, 8'd1);
    chk(dma_req == 1'b1, "R6 request on enable while empty", dma_req, 1);
    for (int i = 0; i < 40; i++) begin
      int t = 0;
      int dl;
      logic [7:0] b;
      while (!dma_req && t < 2000) begin
        @(negedge clk);
        t++;
      end
      chk(dma_req == 1'b1, "R6 request raised", dma_req, 1);
      dl = int'($urandom % 4);
      for (int k = 0; k < dl; k++) begin
        @(negedge clk);
        chk(dma_req == 1'b1, "R6 request held until ack", dma_req, 1);
      end
      b = 8'($urandom);
      dma_ack = 1'b1; dma_data = b;
      exp_q.push_back(b);
      @(negedge clk);
      dma_ack = 1'b0;
      chk(dma_req == 1'b0, "R7 request drops at ack", dma_req, 0);
    end
    bw(2'd1, 8'd0);
    chk(dma_req == 1'b0, "R5 request drops when mode off", dma_req, 0);
    wait_done();
    chk(exp_q.size() == 0, "R7 all DMA bytes sent", exp_q.size(), 0);
    repeat (5) @(negedge clk);
    chk(dma_req == 1'b0, "R5 stays low while off", dma_req, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule